// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Odd Parity

This block turns one byte per write into a frame on a single serial output line. It is the sending half of a full-duplex asynchronous link. It does not make its own bit rate. A separate counter/timer supplies a rate tick, and every bit is held on the line for a fixed number of those ticks. The default is 16 ticks, so the same tick can also drive an oversampling receiver.

Every frame has the same shape:
- a low start bit,
- eight bit slots, least significant first,
- two high stop bits.

Frame length never depends on the parity setting. With parity enabled, the last data slot does not carry data bit 7. It carries odd parity over data bits 0 to 6.

The block raises busy from the accepted write until the second stop bit has finished. At that point it emits a one-cycle interrupt request. A write made while busy is discarded.

Top module: `serial_tx_oddpar`

## Requirements
- R1: After reset and whenever no frame is in progress, `txd_o` is 1, and `busy_o` and `irq_o` are 0.
- R2: A write (`wr_en_i` = 1 while `busy_o` = 0) is accepted at the clock edge. From the next cycle `busy_o` is 1 and `txd_o` is 0 for the start bit (slot 0).
- R3: Slots 1 to 8 follow the start bit and carry the data least significant bit first: slot k+1 holds data bit k. With parity disabled (`par_en_i` = 0), slot 8 carries data bit 7.
- R4: With parity enabled (`par_en_i` = 1 at the accepted write), slot 8 carries odd parity over data bits 0 to 6. That is, the count of ones in slots 1 to 8 is odd, and data bit 7 is not sent.
- R5: Slots 9 and 10 are stop bits at 1. A frame is always 11 slots long with parity on or off.
- R6: Each slot lasts exactly `TICKS_PER_BIT` clock cycles in which `tick_i` is 1. Cycles with `tick_i` = 0 never advance the frame, and a tick in the write cycle itself is not counted.
- R7: `busy_o` stays 1 until the clock edge that counts the last tick of slot 10, then returns to 0 with `txd_o` at 1.
- R8: `irq_o` is 1 for exactly one cycle per frame, in the first cycle in which `busy_o` is 0 again.
- R9: While `busy_o` is 1, `wr_en_i`, `wr_data_i` and changes of `par_en_i` have no effect on the frame being sent.
- R10: A write presented in the cycle where `irq_o` is 1 is accepted, so frames may run back to back with no idle slot between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_data_i | input | DATA_W | Byte to send |
| wr_en_i | input | 1 | Write strobe, taken only when idle |
| par_en_i | input | 1 | 1 = put odd parity in the top data slot, sampled at the write |
| tick_i | input | 1 | Bit-rate tick from an external timer |
| txd_o | output | 1 | Serial output line, idles high |
| busy_o | output | 1 | Frame in progress |
| irq_o | output | 1 | One-cycle pulse after each finished frame |

## Verification
The bench builds the transmitter with 8 data bits and two stop bits, but with only 4 ticks per slot. A full frame then takes under a hundred cycles. This makes it possible to send all 256 byte values with parity off and again with parity on, and to compare the line against an arithmetic model in every cycle of every frame.

The tick is driven with an irregular pattern, so stalled cycles and the exact edge where each slot ends are covered. Most frames start in the interrupt cycle of the previous one. Others are preceded by idle gaps, and some carry stray writes and parity flips in the middle of the frame.

// File: rtl/txs_pkg.sv
package txs_pkg;

   typedef enum logic [0:0] {
      TXS_IDLE = 1'b0,
      TXS_SEND = 1'b1
   } txs_state_e;

   // Odd parity bit: makes total ones (data plus this bit) odd.
   function automatic logic odd_bit(input logic [31:0] v, input int unsigned n);
      logic acc;
      acc = 1'b1;
      for (int unsigned i = 0; i < 32; i++) begin
         if (i < n) acc = acc ^ v[i];
      end
      return acc;
   endfunction

endpackage

// File: rtl/txs_frame_build.sv
module txs_frame_build #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned STOP_BITS = 2,
   localparam int unsigned FRAME_W  = 1 + DATA_W + STOP_BITS
) (
   input  logic [DATA_W-1:0]  data_i,
   input  logic               par_en_i,
   output logic [FRAME_W-1:0] frame_o
);
   import txs_pkg::*;

   logic [DATA_W:0]      body;
   logic [STOP_BITS-1:0] stop_bits;

   always_comb begin
      body            = {data_i, 1'b0};
      if (par_en_i) begin
         body[DATA_W] = odd_bit(32'(data_i[DATA_W-2:0]), DATA_W - 1);
      end
   end

   for (genvar s = 0; s < STOP_BITS; s++) begin : g_stop
      assign stop_bits[s] = 1'b1;
   end

   assign frame_o = {stop_bits, body};

   // R4
   always_comb begin
      if (par_en_i && !$isunknown(data_i)) begin
         odd_slots_chk: assert ((^frame_o[DATA_W:1]) == 1'b1)
            else $error("parity slot does not make the data slots odd");
      end
   end

endmodule

// File: rtl/txs_bit_timer.sv
module txs_bit_timer #(
   parameter int unsigned TICKS_PER_BIT = 16,
   localparam int unsigned CNT_W = $clog2(TICKS_PER_BIT)
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clear_i,
   input  logic run_i,
   input  logic tick_i,
   output logic bit_end_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             at_top;

   assign at_top    = (cnt_q == CNT_W'(TICKS_PER_BIT - 1));
   assign bit_end_o = run_i & tick_i & at_top;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (run_i && tick_i) begin
         cnt_q <= at_top ? '0 : cnt_q + 1'b1;
      end
   end

   // R6
   tick_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CNT_W'(TICKS_PER_BIT - 1));

   // R6
   no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !clear_i) |=> $stable(cnt_q));

endmodule

// File: rtl/txs_shifter.sv
module txs_shifter #(
   parameter int unsigned FRAME_W = 11,
   localparam int unsigned IDX_W  = $clog2(FRAME_W)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               load_i,
   input  logic [FRAME_W-1:0] frame_i,
   input  logic               advance_i,
   output logic               txd_o,
   output logic               last_o
);

   logic [FRAME_W-1:0] shreg_q;
   logic [IDX_W-1:0]   idx_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         shreg_q <= '1;
         idx_q   <= '0;
      end else if (load_i) begin
         shreg_q <= frame_i;
         idx_q   <= '0;
      end else if (advance_i) begin
         shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
         idx_q   <= last_o ? '0 : idx_q + 1'b1;
      end
   end

   assign txd_o  = shreg_q[0];
   assign last_o = (idx_q == IDX_W'(FRAME_W - 1));

   // R5
   stop_slot_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      last_o |-> txd_o);

   // R5
   idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      idx_q <= IDX_W'(FRAME_W - 1));

endmodule

// File: rtl/serial_tx_oddpar.sv
module serial_tx_oddpar #(
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned STOP_BITS     = 2,
   parameter int unsigned TICKS_PER_BIT = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              wr_en_i,
   input  logic              par_en_i,
   input  logic              tick_i,
   output logic              txd_o,
   output logic              busy_o,
   output logic              irq_o
);
   import txs_pkg::*;

   localparam int unsigned FRAME_W = 1 + DATA_W + STOP_BITS;

   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be at least 2");
   end
   if (STOP_BITS < 1) begin : g_bad_stop
      $error("STOP_BITS must be at least 1");
   end
   if (TICKS_PER_BIT < 2) begin : g_bad_ticks
      $error("TICKS_PER_BIT must be at least 2");
   end

   txs_state_e         state_q;
   logic               irq_q;
   logic               load;
   logic               bit_end;
   logic               last_slot;
   logic               done;
   logic [FRAME_W-1:0] frame;

   assign load = wr_en_i && (state_q == TXS_IDLE);
   assign done = (state_q == TXS_SEND) && bit_end && last_slot;

   txs_frame_build #(
      .DATA_W    (DATA_W),
      .STOP_BITS (STOP_BITS)
   ) frame_i (
      .data_i   (wr_data_i),
      .par_en_i (par_en_i),
      .frame_o  (frame)
   );

   txs_bit_timer #(
      .TICKS_PER_BIT (TICKS_PER_BIT)
   ) timer_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clear_i   (load),
      .run_i     (state_q == TXS_SEND),
      .tick_i    (tick_i),
      .bit_end_o (bit_end)
   );

   txs_shifter #(
      .FRAME_W (FRAME_W)
   ) shift_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load),
      .frame_i   (frame),
      .advance_i (bit_end),
      .txd_o     (txd_o),
      .last_o    (last_slot)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= TXS_IDLE;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= done;
         if (load) begin
            state_q <= TXS_SEND;
         end else if (done) begin
            state_q <= TXS_IDLE;
         end
      end
   end

   assign busy_o = (state_q == TXS_SEND);
   assign irq_o  = irq_q;

   // R1
   idle_line_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> txd_o);

   // R2
   start_bit_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> !txd_o);

   // R8
   irq_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |=> !irq_o);

   // R7
   irq_at_busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o == $fell(busy_o));

   // R9
   busy_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && wr_en_i && !bit_end) |=> (busy_o && $stable(txd_o)));

endmodule

// File: tb/serial_tx_oddpar_tb_top.sv
module serial_tx_oddpar_tb_top;

   localparam int unsigned DW     = 8;
   localparam int unsigned TPB    = 4;
   localparam int unsigned SLOTS  = 11;
   localparam int unsigned LIMIT  = SLOTS * TPB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          wr_en = 1'b0;
   logic          par_en = 1'b0;
   logic          tick = 1'b0;
   logic          txd;
   logic          busy;
   logic          irq;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   bit ended  = 1'b0;

   always #2.5 clk = ~clk;

   serial_tx_oddpar #(
      .DATA_W        (DW),
      .STOP_BITS     (2),
      .TICKS_PER_BIT (TPB)
   ) dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .wr_data_i (wr_data),
      .wr_en_i   (wr_en),
      .par_en_i  (par_en),
      .tick_i    (tick),
      .txd_o     (txd),
      .busy_o    (busy),
      .irq_o     (irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic logic next_tick();
      cyc++;
      return ((cyc * 7) % 5) < 3;
   endfunction

   // One frame, called and returning at a falling edge.
   task automatic send(input logic [DW-1:0] d, input bit par, input bit stray, input bit b2b);
      logic [SLOTS-1:0] ex;
      int n;
      int slot;
      string tag;
      ex[0] = 1'b0;
      for (int i = 0; i < 7; i++) ex[i+1] = d[i];
      ex[8]  = par ? ~^d[6:0] : d[7];
      ex[9]  = 1'b1;
      ex[10] = 1'b1;
      wr_data = d;
      par_en  = par;
      wr_en   = 1'b1;
      tick    = next_tick();
      n = 0;
      while (n < LIMIT) begin
         @(negedge clk);
         wr_en = 1'b0;
         slot  = n / TPB;
         if (slot == 0)      tag = (n == 0 && b2b) ? "R10" : "R2";
         else if (slot < 8)  tag = "R3";
         else if (slot == 8) tag = par ? "R4" : "R3";
         else                tag = "R5";
         if (n > 0 && (n % TPB) == 0) tag = {tag, "/R6"};
         if (stray && n >= 10) tag = {tag, "/R9"};
         chk(txd == ex[slot], tag, int'(txd), int'(ex[slot]));
         chk(busy == 1'b1, "R7", int'(busy), 1);
         chk(irq == 1'b0, "R8", int'(irq), 0);
         if (stray && (n == 10 || n == 25)) begin
            wr_en   = 1'b1;
            wr_data = ~d;
            par_en  = ~par;
         end
         tick = next_tick();
         if (tick) n++;
      end
      @(negedge clk);
      wr_en = 1'b0;
      chk(busy == 1'b0, "R7", int'(busy), 0);
      chk(irq == 1'b1, "R8", int'(irq), 1);
      chk(txd == 1'b1, "R1", int'(txd), 1);
   endtask

   task automatic idle_gap(input int len);
      for (int i = 0; i < len; i++) begin
         tick = next_tick();
         @(negedge clk);
         chk(irq == 1'b0, "R8", int'(irq), 0);
         chk(busy == 1'b0 && txd == 1'b1, "R1", int'({busy, txd}), 1);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(txd == 1'b1, "R1", int'(txd), 1);
      chk(busy == 1'b0, "R1", int'(busy), 0);
      chk(irq == 1'b0, "R1", int'(irq), 0);
      rst_n = 1'b1;
      @(negedge clk);
      idle_gap(5);
      for (int p = 0; p < 2; p++) begin
         for (int v = 0; v < 256; v++) begin
            send(8'(v), p[0], (v % 7) == 3, (v % 16) != 0);
            if ((v % 16) == 15) idle_gap(3);
         end
      end
      idle_gap(4);
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!ended) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule